// File: doc/BRIEF.md
# Table-Read Engine

This block moves words from program memory into the data register file on request. A start strobe launches one operation. In direct mode the operation makes a single transfer to the given register address. In indirect mode it makes as many transfers as the repeat count gives, and each one lands in the next register. The engine keeps its own table pointer, which a load strobe sets while the engine is idle. The pointer steps by one for every word moved.

Program memory is reached through a synchronous read port outside the block, with one cycle of latency: the engine drives the address, and the word comes back on the following cycle. Because of that latency, the first read of a run needs a fetch cycle before its write. After each transfer the engine has already asked for the word at the next pointer. That word stays usable for exactly one idle cycle. A start that arrives in that cycle skips the fetch. A start that arrives later pays for the fetch again.

A cycle counter reports how many busy cycles the most recent operation used, so the cost model can be checked from outside.

Top module: `tblrd_engine`

## Requirements
- R1: A read started while no prefetched word is held keeps busy high for exactly 2 cycles. It makes one write, in the second of those cycles, of the word at the table pointer. The cycle counter then reads 2.
- R2: A read whose start is asserted in the first idle cycle after a transferring operation keeps busy high for 1 cycle. It writes the word at the already stepped pointer, and the cycle counter reads 1.
- R3: A read whose start comes two or more idle cycles after the previous operation again takes 2 busy cycles.
- R4: In indirect mode (indirect=1) with a repeat count N>0, the engine makes N writes to addresses dest_addr, dest_addr+1, and so on, wrapping modulo 2^REG_AW. This takes N+1 busy cycles from a cold start, or N when the start is back-to-back.
- R5: The table pointer advances by one after every transfer and wraps at 2^PM_AW. Each written word is the program word at the pointer value of that transfer.
- R6: In indirect mode a repeat count of 0 gives 1 busy cycle, no write and no pointer change. A read started right after it costs 2 cycles.
- R7: A start asserted while busy is ignored. It causes no extra write, no change to the running operation, and no operation afterwards.
- R8: In direct mode (indirect=0) the repeat count is ignored, and exactly one write goes to dest_addr.
- R9: A pointer load accepted while idle sets the table pointer and discards any prefetched word. A read started in the same cycle therefore reads from the loaded pointer and takes 2 cycles.
- R10: During and right after reset, busy, reg_we and cyc_count are 0.
- R11: reg_we is high only in busy cycles, and the last write of an operation falls in its final busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when idle |
| indirect | input | 1 | 1: repeat mode into consecutive registers; 0: single transfer |
| dest_addr | input | REG_AW | First destination register |
| rep_count | input | CNT_W | Transfer count for indirect mode |
| ptr_load | input | 1 | Loads the table pointer when idle |
| ptr_value | input | PM_AW | Value for a pointer load |
| pm_addr | output | PM_AW | Program-memory read address |
| pm_data | input | DATA_W | Program-memory read data, one cycle after the address |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | REG_AW | Register write address |
| reg_data | output | DATA_W | Register write data |
| busy | output | 1 | Operation in progress |
| cyc_count | output | CNT_W+1 | Busy cycles used by the latest operation |

## Verification
The bench goes after the one-cycle window in which the prefetched word can be used. If the window were too wide, a gapped read would finish in 1 cycle. If it were missing, a back-to-back read would take 2. If the prefetch aimed at the wrong address, the write data would repeat or skip a word. Other cases covered are a zero-count repeat, which must neither write nor keep the run alive, and pointer and destination wrap-around. A pointer load that coincides with a start must not use a stale prefetched word. A start pulse during a long repeat must not add writes or launch a second operation.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_NOP   = 2'd3
  } tr_state_t;
endpackage

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             indirect,
  input  logic [CNT_W-1:0] count,
  input  logic             ptr_load,
  output logic             idle,
  output logic             accept,
  output logic             xfer,
  output logic             ind_mode
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  tr_state_t        state_q;
  logic [CNT_W-1:0] left_q;
  logic             pf_q;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && start;
  assign xfer   = (state_q == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      pf_q     <= 1'b0;
      ind_mode <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          pf_q <= 1'b0;
          if (start) begin
            ind_mode <= indirect;
            if (indirect && count == '0) begin
              state_q <= ST_NOP;
            end else begin
              left_q  <= indirect ? count : ONE;
              state_q <= (pf_q && !ptr_load) ? ST_XFER : ST_FETCH;
            end
          end
        end
        ST_FETCH: state_q <= ST_XFER;
        ST_XFER: begin
          if (left_q == ONE) begin
            state_q <= ST_IDLE;
            pf_q    <= 1'b1;
          end else begin
            left_q <= left_q - ONE;
          end
        end
        ST_NOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_THEN_XFER: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_XFER)); // R1
  AST_GAP_COSTS_FETCH: assert property (@(posedge clk) disable iff (rst)
    (idle && start && $past(idle && !start)) |=> (state_q != ST_XFER)); // R3
  AST_NOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NOP) |=> (state_q == ST_IDLE)); // R6
  AST_LOAD_DROPS_PF: assert property (@(posedge clk) disable iff (rst)
    (accept && ptr_load) |=> (state_q != ST_XFER)); // R9
endmodule

// File: rtl/tblrd_tptr.sv
module tblrd_tptr #(
  parameter int PM_AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             load,
  input  logic [PM_AW-1:0] load_val,
  input  logic             step,
  output logic [PM_AW-1:0] pm_addr
);
  localparam logic [PM_AW-1:0] ONE = {{(PM_AW-1){1'b0}}, 1'b1};

  logic [PM_AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)               ptr_q <= '0;
    else if (idle && load) ptr_q <= load_val;
    else if (step)         ptr_q <= ptr_q + ONE;
  end

  // During a transfer the read port already fetches the following word.
  assign pm_addr = step ? (ptr_q + ONE) : ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> (ptr_q == $past(ptr_q) + ONE)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !(idle && load)) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/tblrd_dest.sv
module tblrd_dest #(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [REG_AW-1:0] dest_in,
  input  logic              step,
  input  logic              ind_mode,
  output logic [REG_AW-1:0] dest
);
  localparam logic [REG_AW-1:0] ONE = {{(REG_AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                    dest <= '0;
    else if (accept)            dest <= dest_in;
    else if (step && ind_mode)  dest <= dest + ONE;
  end

  AST_DEST_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && ind_mode) |=> (dest == $past(dest) + ONE)); // R4
endmodule

// File: rtl/tblrd_cycles.sv
module tblrd_cycles #(
  parameter int CYC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             busy,
  output logic [CYC_W-1:0] cyc
);
  localparam logic [CYC_W-1:0] ONE = {{(CYC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)         cyc <= '0;
    else if (accept) cyc <= '0;
    else if (busy)   cyc <= cyc + ONE;
  end

  AST_CYC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> $stable(cyc)); // R1
endmodule

// File: rtl/tblrd_engine.sv
module tblrd_engine #(
  parameter int PM_AW  = 10,
  parameter int DATA_W = 16,
  parameter int REG_AW = 8,
  parameter int CNT_W  = 8,
  localparam int CYC_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              indirect,
  input  logic [REG_AW-1:0] dest_addr,
  input  logic [CNT_W-1:0]  rep_count,
  input  logic              ptr_load,
  input  logic [PM_AW-1:0]  ptr_value,
  output logic [PM_AW-1:0]  pm_addr,
  input  logic [DATA_W-1:0] pm_data,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              busy,
  output logic [CYC_W-1:0]  cyc_count
);
  logic idle, accept, xfer, ind_mode;

  tblrd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .indirect(indirect),
    .count(rep_count), .ptr_load(ptr_load), .idle(idle),
    .accept(accept), .xfer(xfer), .ind_mode(ind_mode)
  );

  tblrd_tptr #(.PM_AW(PM_AW)) u_tptr (
    .clk(clk), .rst(rst), .idle(idle), .load(ptr_load),
    .load_val(ptr_value), .step(xfer), .pm_addr(pm_addr)
  );

  tblrd_dest #(.REG_AW(REG_AW)) u_dest (
    .clk(clk), .rst(rst), .accept(accept), .dest_in(dest_addr),
    .step(xfer), .ind_mode(ind_mode), .dest(reg_addr)
  );

  tblrd_cycles #(.CYC_W(CYC_W)) u_cyc (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy), .cyc(cyc_count)
  );

  assign busy     = !idle;
  assign reg_we   = xfer;
  assign reg_data = pm_data;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !reg_we) |=> $stable(reg_addr)); // R7
endmodule

// File: tb/tblrd_engine_tb.sv
module tblrd_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, indirect = 1'b0, ptr_load = 1'b0;
  logic [7:0]  dest_addr = '0, rep_count = '0;
  logic [9:0]  ptr_value = '0, pm_addr;
  logic [15:0] pm_data, reg_data;
  logic        reg_we, busy;
  logic [7:0]  reg_addr;
  logic [8:0]  cyc_count;

  int total = 0, bad = 0, stray = 0;
  logic [9:0] mptr = '0;

  always #5 clk = ~clk;

  tblrd_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .indirect(indirect),
    .dest_addr(dest_addr), .rep_count(rep_count), .ptr_load(ptr_load),
    .ptr_value(ptr_value), .pm_addr(pm_addr), .pm_data(pm_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
    .busy(busy), .cyc_count(cyc_count)
  );

  function automatic logic [15:0] rom(input logic [9:0] a);
    return 16'h1234 + {6'd0, a} * 16'd97;
  endfunction

  always_ff @(posedge clk) pm_data <= rom(pm_addr);

  always @(negedge clk) if (!rst && reg_we && !busy) stray++; // R11

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at a negedge in the first idle cycle after the previous operation.
  task automatic run_op(input int gap, input bit ind, input logic [7:0] cnt,
                        input logic [7:0] dst, input int exp_cyc, input int exp_wr,
                        input string req, input bit poke, input bit ld,
                        input logic [9:0] ldv);
    int n = 0, nw = 0;
    repeat (gap) @(negedge clk);
    start = 1'b1; indirect = ind; rep_count = cnt; dest_addr = dst;
    ptr_load = ld; ptr_value = ldv;
    if (ld) mptr = ldv;
    @(negedge clk);
    start = 1'b0; ptr_load = 1'b0;
    while (busy && n < 1000) begin
      n++;
      if (reg_we) begin
        chk(reg_addr == dst + 8'(nw), {req, " addr"}, int'(reg_addr), int'(dst + 8'(nw)));
        chk(reg_data == rom(mptr), {req, " data"}, int'(reg_data), int'(rom(mptr)));
        mptr = mptr + 10'd1;
        nw++;
      end
      if (poke && n == 1) begin start = 1'b1; indirect = 1'b0; dest_addr = 8'h99; end
      if (poke && n == 2) start = 1'b0;
      @(negedge clk);
    end
    chk(n == exp_cyc, {req, " busy cycles"}, n, exp_cyc);
    chk(int'(cyc_count) == exp_cyc, {req, " cyc_count"}, int'(cyc_count), exp_cyc);
    chk(nw == exp_wr, {req, " writes"}, nw, exp_wr);
  endtask

  // {gap, ind, count, dest, exp_cycles, exp_writes}
  localparam logic [39:0] VEC [10] = '{
    {4'd0, 4'd0, 8'd5,  8'h10, 8'd2,  8'd1},
    {4'd0, 4'd0, 8'd0,  8'h11, 8'd1,  8'd1},
    {4'd0, 4'd0, 8'd0,  8'h12, 8'd1,  8'd1},
    {4'd2, 4'd0, 8'd0,  8'h20, 8'd2,  8'd1},
    {4'd0, 4'd1, 8'd10, 8'h40, 8'd10, 8'd10},
    {4'd3, 4'd1, 8'd10, 8'h60, 8'd11, 8'd10},
    {4'd0, 4'd1, 8'd0,  8'h70, 8'd1,  8'd0},
    {4'd0, 4'd0, 8'd0,  8'h21, 8'd2,  8'd1},
    {4'd1, 4'd1, 8'd1,  8'hFF, 8'd2,  8'd1},
    {4'd0, 4'd1, 8'd3,  8'hFE, 8'd3,  8'd3}
  };
  string vtag [10];

  initial begin
    vtag[0] = "R1_R8 cold direct";  vtag[1] = "R2 back-to-back";
    vtag[2] = "R2_R5 back-to-back"; vtag[3] = "R3 gapped";
    vtag[4] = "R4 warm repeat";     vtag[5] = "R4 cold repeat";
    vtag[6] = "R6 zero count";      vtag[7] = "R6 after zero";
    vtag[8] = "R4 repeat one";      vtag[9] = "R4_R5 wrap dest";
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk(reg_we == 1'b0, "R10 reg_we", int'(reg_we), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cyc_count == '0, "R10 cyc_count", int'(cyc_count), 0);
    for (int i = 0; i < 10; i++) begin
      run_op(int'(VEC[i][39:36]), VEC[i][32], VEC[i][31:24], VEC[i][23:16],
             int'(VEC[i][15:8]), int'(VEC[i][7:0]), vtag[i], 1'b0, 1'b0, '0);
    end
    // R9: load together with a back-to-back start; pointer wraps at the top
    run_op(0, 1'b1, 8'd3, 8'h30, 4, 3, "R9_R5 load", 1'b0, 1'b1, 10'h3FE);
    // R7: start pulse in the middle of a cold four-word repeat
    run_op(2, 1'b1, 8'd4, 8'h80, 5, 4, "R7 busy start", 1'b1, 1'b0, '0);
    for (int k = 0; k < 3; k++) begin
      chk(busy == 1'b0 && reg_we == 1'b0, "R7 no late op", int'(busy), 0);
      @(negedge clk);
    end
    chk(stray == 0, "R11 write outside busy", stray, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule